// File: doc/BRIEF.md
# Programmable Envelope Generator

This block produces a 5-bit volume envelope for a sound channel. A 16-bit period value, given as a coarse byte and a fine byte, sets how fast a 32-position step counter advances. A 4-bit shape code sets the pattern: a single decay or attack, a repeating sawtooth, a triangle, or a single ramp that then freezes.

Each write to the shape code restarts the prescaler and the counter together. The new ramp therefore starts on a known clock edge.

The sequencer is a three-state machine:
- `ST_MUTE`: level 0, frozen. This is the reset state.
- `ST_RAMP`: the counter steps.
- `ST_HOLD`: the level is frozen at an extreme.

The transitions are:
- Reset enters `ST_MUTE`.
- Any shape write enters `ST_RAMP` from every state.
- At the end of a 32-step cycle in `ST_RAMP`:
  - with the continue bit clear, the machine goes to `ST_MUTE`;
  - with continue and freeze both set, it goes to `ST_HOLD`;
  - with continue set and freeze clear, it wraps back into `ST_RAMP` for the next cycle.

Top module: `env_shaper`

## Requirements
- R1: After reset, and until the first shape write, `level` is 0 and `holding` is 1.
- R2: The effective period is EP = {`period_coarse`, `period_fine`}, and an EP of 0 acts as 1. After a shape write, the level first changes 8*EP clocks later and then once per 8*EP clocks.
- R3: A shape write (`shape_we`=1) restarts the envelope from any state. The shape code is bit 3 continue, bit 2 attack, bit 1 alternate, bit 0 freeze. On the following clock `level` is 0 if attack is 1 and 31 otherwise, and `holding` is 0.
- R4: During the first 32 positions the level moves by one per step: upward 0..31 with attack=1, downward 31..0 with attack=0.
- R5: With continue=0, after the 32nd position the level is 0 and `holding` is 1. The alternate and freeze bits have no effect in this case.
- R6: With continue=1, freeze=1 and alternate=0, the level freezes at the last ramp value and `holding` is 1.
- R7: With continue=1, freeze=1 and alternate=1, the level freezes at the opposite extreme (0 after a rise, 31 after a fall) and `holding` is 1.
- R8: With continue=1, freeze=0 and alternate=0, the ramp repeats in the same direction (sawtooth) and `holding` stays 0.
- R9: With continue=1, freeze=0 and alternate=1, the direction reverses every 32 positions, so each extreme appears on two consecutive steps (triangle).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| period_coarse | input | 8 | Upper byte of the step period |
| period_fine | input | 8 | Lower byte of the step period |
| shape_we | input | 1 | Shape write strobe; restarts the envelope |
| shape_din | input | 4 | Shape code {continue, attack, alternate, freeze} |
| level | output | 5 | Envelope level |
| holding | output | 1 | High while the level is frozen (muted or held) |

## Verification
A wrong direction flag or step position shows on `level` at the next prescaler tick, at most 8*EP clocks after the fault. A wrong state appears immediately as a `holding` value that disagrees with the shape code. A miscounted prescaler shifts every later step edge, so comparing against the model on every clock exposes it at the first tick. End-of-cycle mistakes only surface at position 32, so each shape code is run well past one full cycle at the shortest period.

// File: rtl/env_shaper_pkg.sv
package env_shaper_pkg;

    typedef enum logic [1:0] {
        ST_MUTE = 2'd0,
        ST_RAMP = 2'd1,
        ST_HOLD = 2'd2
    } env_state_e;

    // bit positions inside the shape code
    localparam int SHP_FREEZE = 0;
    localparam int SHP_ALT    = 1;
    localparam int SHP_ATT    = 2;
    localparam int SHP_CONT   = 3;
    localparam int SHP_W      = 4;

endpackage

// File: rtl/env_prescaler.sv
module env_prescaler #(
    parameter int PERIOD_W  = 16,
    parameter int PRE_SHIFT = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                restart,
    input  logic [PERIOD_W-1:0] period,
    output logic                step
);
    localparam int CNT_W = PERIOD_W + PRE_SHIFT;

    logic [CNT_W-1:0]    cnt_q;
    logic [PERIOD_W-1:0] ep_eff;
    logic [CNT_W-1:0]    limit;
    logic                at_limit;

    always_comb begin
        ep_eff   = (period == '0) ? PERIOD_W'(1) : period;
        limit    = {ep_eff, {PRE_SHIFT{1'b0}}} - CNT_W'(1);
        at_limit = (cnt_q >= limit);
        step     = at_limit && !restart;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (restart || at_limit) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end
endmodule

// File: rtl/env_sequencer.sv
module env_sequencer
    import env_shaper_pkg::*;
#(
    parameter int LEVEL_W = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               restart,
    input  logic               start_up,
    input  logic               step,
    input  logic               cfg_cont,
    input  logic               cfg_alt,
    input  logic               cfg_freeze,
    output logic [LEVEL_W-1:0] level,
    output logic               holding
);
    localparam logic [LEVEL_W-1:0] POS_LAST = '1;

    env_state_e         state_q, state_d;
    logic [LEVEL_W-1:0] pos_q, pos_d;
    logic               rising_q, rising_d;

    // next-state logic
    always_comb begin
        state_d  = state_q;
        pos_d    = pos_q;
        rising_d = rising_q;
        if (restart) begin
            state_d  = ST_RAMP;
            pos_d    = '0;
            rising_d = start_up;
        end else if (step) begin
            unique case (state_q)
                ST_RAMP: begin
                    if (pos_q != POS_LAST) begin
                        pos_d = pos_q + LEVEL_W'(1);
                    end else if (!cfg_cont) begin
                        state_d = ST_MUTE;
                    end else if (cfg_freeze) begin
                        state_d = ST_HOLD;
                        if (cfg_alt) rising_d = ~rising_q;
                    end else begin
                        pos_d = '0;
                        if (cfg_alt) rising_d = ~rising_q;
                    end
                end
                ST_HOLD: ;
                ST_MUTE: ;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_MUTE;
            pos_q    <= '0;
            rising_q <= 1'b0;
        end else begin
            state_q  <= state_d;
            pos_q    <= pos_d;
            rising_q <= rising_d;
        end
    end

    // outputs
    always_comb begin
        unique case (state_q)
            ST_MUTE: begin
                level   = '0;
                holding = 1'b1;
            end
            ST_HOLD: begin
                level   = rising_q ? pos_q : ~pos_q;
                holding = 1'b1;
            end
            ST_RAMP: begin
                level   = rising_q ? pos_q : ~pos_q;
                holding = 1'b0;
            end
            default: begin
                level   = '0;
                holding = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/env_shaper.sv
module env_shaper
    import env_shaper_pkg::*;
#(
    parameter int HALF_W    = 8,
    parameter int LEVEL_W   = 5,
    parameter int PRE_SHIFT = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [HALF_W-1:0]  period_coarse,
    input  logic [HALF_W-1:0]  period_fine,
    input  logic               shape_we,
    input  logic [SHP_W-1:0]   shape_din,
    output logic [LEVEL_W-1:0] level,
    output logic               holding
);
    localparam int PERIOD_W = 2 * HALF_W;

    logic [SHP_W-1:0]    shape_bits_q;
    logic [PERIOD_W-1:0] period;
    logic                step;

    assign period = {period_coarse, period_fine};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shape_bits_q <= '0;
        end else if (shape_we) begin
            shape_bits_q <= shape_din;
        end
    end

    env_prescaler #(
        .PERIOD_W (PERIOD_W),
        .PRE_SHIFT(PRE_SHIFT)
    ) u_prescaler (
        .clk    (clk),
        .rst_n  (rst_n),
        .restart(shape_we),
        .period (period),
        .step   (step)
    );

    env_sequencer #(
        .LEVEL_W(LEVEL_W)
    ) u_sequencer (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart   (shape_we),
        .start_up  (shape_din[SHP_ATT]),
        .step      (step),
        .cfg_cont  (shape_bits_q[SHP_CONT]),
        .cfg_alt   (shape_bits_q[SHP_ALT]),
        .cfg_freeze(shape_bits_q[SHP_FREEZE]),
        .level     (level),
        .holding   (holding)
    );
endmodule

// File: rtl/env_shaper_chk.sv
module env_shaper_chk #(
    parameter int LEVEL_W = 5
) (
    input logic               clk,
    input logic               rst_n,
    input logic               shape_we,
    input logic               att_in,
    input logic               cont_q,
    input logic               freeze_q,
    input logic [LEVEL_W-1:0] level,
    input logic               holding
);
    AST_START_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
        shape_we |=> (!holding && level == {LEVEL_W{~$past(att_in)}})); // R3

    AST_UNIT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!shape_we && !holding && level != '0 && level != '1) |=>
        (level == $past(level) || level == $past(level) + LEVEL_W'(1) ||
         level == $past(level) - LEVEL_W'(1))); // R4

    AST_MUTE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (holding && !cont_q) |-> (level == '0)); // R5

    AST_FROZEN_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (holding && !shape_we) |=> (holding && $stable(level))); // R6

    AST_LOOP_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (cont_q && !freeze_q) |-> !holding); // R8
endmodule

bind env_shaper env_shaper_chk #(.LEVEL_W(LEVEL_W)) i_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .shape_we(shape_we),
    .att_in  (shape_din[2]),
    .cont_q  (shape_bits_q[3]),
    .freeze_q(shape_bits_q[0]),
    .level   (level),
    .holding (holding)
);

// File: tb/test_env_shaper.sv
module test_env_shaper;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [7:0] coarse, fine;
    logic       we;
    logic [3:0] din;
    wire  [4:0] level;
    wire        holding;

    always #5 clk = ~clk;

    env_shaper i_env_shaper (
        .clk(clk), .rst_n(rst_n), .period_coarse(coarse), .period_fine(fine),
        .shape_we(we), .shape_din(din), .level(level), .holding(holding)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // behavioural reference: steps since last write, clocks since last step
    bit         m_muted = 1;
    int         m_k = 0, m_cs = 0, m_ep = 1;
    logic [3:0] m_shape = 4'h0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_muted = 1; m_k = 0; m_cs = 0;
        end else if (we) begin
            m_muted = 0; m_k = 0; m_cs = 0; m_shape = din;
            m_ep = {coarse, fine};
            if (m_ep == 0) m_ep = 1;
        end else if (!m_muted) begin
            m_cs++;
            if (m_cs == 8 * m_ep) begin
                m_k++; m_cs = 0;
            end
        end
    end

    function automatic int ramp(bit up, int ph);
        return up ? ph : 31 - ph;
    endfunction

    function automatic int exp_level();
        bit cont = m_shape[3], att = m_shape[2], alt = m_shape[1], frz = m_shape[0];
        if (m_muted) return 0;
        if (m_k < 32) return ramp(att, m_k);
        if (!cont) return 0;
        if (frz) return alt ? (att ? 0 : 31) : (att ? 31 : 0);
        return ramp(att ^ (alt && ((m_k / 32) % 2 == 1)), m_k % 32);
    endfunction

    function automatic int exp_hold();
        if (m_muted) return 1;
        return ((!m_shape[3] || m_shape[0]) && m_k >= 32) ? 1 : 0;
    endfunction

    function automatic string req_tag();
        if (m_muted) return "R1";
        if (m_k == 0) return "R3";
        if (m_k < 32) return "R4";
        if (!m_shape[3]) return "R5";
        if (m_shape[0]) return m_shape[1] ? "R7" : "R6";
        return m_shape[1] ? "R9" : "R8";
    endfunction

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // compare against the model on every clock, away from the active edge
    always @(negedge clk) begin
        if (!done) begin
            chk({req_tag(), " level"}, int'(level), exp_level());
            chk({req_tag(), " holding"}, int'(holding), exp_hold());
        end
    end

    task automatic wr(input logic [3:0] s, input logic [7:0] c, input logic [7:0] f);
        @(negedge clk);
        coarse = c; fine = f; din = s; we = 1'b1;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic run(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        rst_n = 1'b0; we = 1'b0; din = 4'h0; coarse = 8'h00; fine = 8'h00;
        run(3);
        chk("R1 reset level", int'(level), 0);
        chk("R1 reset holding", int'(holding), 1);
        rst_n = 1'b1;
        run(20);
        chk("R1 idle level", int'(level), 0);
        chk("R1 idle holding", int'(holding), 1);

        // R2: EP=2, decay, first step after 16 clocks
        wr(4'b0000, 8'h00, 8'h02);
        chk("R3 start decay", int'(level), 31);
        run(15);
        chk("R2 before tick", int'(level), 31);
        run(1);
        chk("R2 at tick", int'(level), 30);
        run(40 * 16);

        // R2: EP=0 acts as 1, attack
        wr(4'b0100, 8'h00, 8'h00);
        run(7);
        chk("R2 ep0 before", int'(level), 0);
        run(1);
        chk("R2 ep0 at tick", int'(level), 1);
        run(300);

        // R5: continue clear, alternate/freeze ignored
        wr(4'b0011, 8'h00, 8'h00);
        run(300);
        chk("R5 decay end level", int'(level), 0);
        chk("R5 decay end holding", int'(holding), 1);
        wr(4'b0111, 8'h00, 8'h00);
        run(300);
        chk("R5 attack end level", int'(level), 0);

        // R6 / R7: freeze
        wr(4'b1001, 8'h00, 8'h00); run(300);
        chk("R6 freeze final low", int'(level), 0);
        wr(4'b1101, 8'h00, 8'h00); run(300);
        chk("R6 freeze final high", int'(level), 31);
        chk("R6 holding", int'(holding), 1);
        wr(4'b1011, 8'h00, 8'h00); run(300);
        chk("R7 freeze opposite high", int'(level), 31);
        wr(4'b1111, 8'h00, 8'h00); run(300);
        chk("R7 freeze opposite low", int'(level), 0);

        // R8 / R9: repeating shapes
        wr(4'b1000, 8'h00, 8'h00); run(800);
        wr(4'b1100, 8'h00, 8'h00); run(800);
        wr(4'b1010, 8'h00, 8'h00); run(800);
        wr(4'b1110, 8'h00, 8'h01); run(1100);

        // R3: rewrite mid-ramp restarts immediately
        wr(4'b1100, 8'h00, 8'h01);
        run(100);
        wr(4'b1000, 8'h00, 8'h01);
        chk("R3 restart level", int'(level), 31);
        chk("R3 restart holding", int'(holding), 0);
        run(50);

        // R2: coarse byte supplies upper period bits (EP=256)
        wr(4'b0100, 8'h01, 8'h00);
        run(2047);
        chk("R2 coarse before", int'(level), 0);
        run(1);
        chk("R2 coarse at tick", int'(level), 1);
        run(2048 * 2);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule